// File: doc/BRIEF.md
# Two-Stage Watchdog Reset Timer

This block is a watchdog that software must service through a small 16-bit register bus. A down-counter is loaded from a programmable start value and steps down once per slow tick. The tick comes from a prescaler on the system clock. When the count is zero, the next tick is an expiry. The first expiry raises a first-stage flag and reloads the counter, so it keeps running. If the counter expires again while that flag is still set, the block raises a second-stage flag and a boot flag, and it issues a one-cycle reset request to the system reset logic.

Software normally services the timer by writing to the reload register. It must also clear the first-stage flag, or the next expiry escalates to a reset. A control register holds a halt bit and a no-reboot bit. The halt bit freezes counting. The no-reboot bit masks the reset request, although the flags still record the escalation. The bus is a single-cycle write strobe with an address and write data. Read data is a combinational function of the address.

Top module: `wdt_twostage`

## Requirements
- R1: After reset, the count equals the reset start value and the start-value register reads that same value. The control register reads 0x0800 (halted). Both status registers read 0, and no reset request is issued.
- R2: A write to offset 0x12 with a legal value stores bits [9:0]. Bits [15:10] of that register always read 0, whatever was written to them.
- R3: A write to offset 0x12 whose bits [9:0] are 0, 1, 2 or 3 is ignored, and the stored start value is unchanged. A value of 4 is accepted.
- R4: Any write to offset 0x00, whatever its data, loads the counter from the start value in the next cycle and restarts the tick phase. A read of offset 0x00 returns the count in bits [9:0].
- R5: While bit 11 of offset 0x08 is 0, the counter decreases by one every TICK_DIV clock cycles. The tick after the count reaches zero is an expiry. With start value N, expiries fall every (N+1)*TICK_DIV cycles after a reload.
- R6: While bit 11 of offset 0x08 is 1, the count and the tick phase hold their values.
- R7: An expiry while bit 3 of offset 0x04 is 0 sets that bit, reloads the counter from the start value and issues no reset request.
- R8: An expiry while bit 3 of offset 0x04 is 1 sets bit 1 (second stage) and bit 2 (boot) of offset 0x06. In the same cycle, reset_req is high for exactly one clock cycle, unless it is masked as R10 states.
- R9: If bit 3 of offset 0x04 is cleared before the second expiry, the next expiry acts as a first expiry: it sets bit 3 again and issues no reset.
- R10: While bit 0 of offset 0x08 is 1, reset_req stays low, but the flags are still set as R8 describes. The control register reads back the value last written to it.
- R11: A write of 1 to a status bit clears it, and a write of 0 leaves it unchanged. If an expiry sets a flag in the same cycle that a write clears it, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, also drives the tick prescaler |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the register at bus_addr |
| reset_req | output | 1 | One-cycle reset request to the system reset logic |

## Verification
The bench builds the block with a tick divider of 4 clock cycles and a reset start value of 4, and it programs a start value of 6. A full expiry period is then 28 cycles, so both stages of the escalation, a flag cleared between them, and the masked case all fit into a few hundred cycles. Because the prescaler is so short, every count value can be predicted at an exact cycle offset from the reload. This also makes it possible to check the exact cycle of the reset pulse and the exact cycle in which each flag appears.

// File: rtl/wdt_pkg.sv
// Shared constants for the two-stage watchdog: bus geometry, register
// offsets and the bit positions that software decodes.
package wdt_pkg;

    localparam int WDT_ADDR_W = 5;
    localparam int WDT_DATA_W = 16;
    localparam int WDT_MIN_START = 4;

    localparam logic [WDT_ADDR_W-1:0] OFS_RELOAD = 5'h00;
    localparam logic [WDT_ADDR_W-1:0] OFS_STAT1  = 5'h04;
    localparam logic [WDT_ADDR_W-1:0] OFS_STAT2  = 5'h06;
    localparam logic [WDT_ADDR_W-1:0] OFS_CTRL   = 5'h08;
    localparam logic [WDT_ADDR_W-1:0] OFS_START  = 5'h12;

    localparam int BIT_FIRST    = 3;
    localparam int BIT_SECOND   = 1;
    localparam int BIT_BOOT     = 2;
    localparam int BIT_HALT     = 11;
    localparam int BIT_NOREBOOT = 0;

    localparam logic [WDT_DATA_W-1:0] CTRL_RST = 16'h0800;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_RELOAD,
        SEL_STAT1,
        SEL_STAT2,
        SEL_CTRL,
        SEL_START
    } wdt_sel_e;

endpackage

// File: rtl/wdt_tick_gen.sv
// Tick prescaler. Produces a one-cycle tick every TICK_DIV clocks while
// run is high. The phase is held at zero while stopped and restarted by
// restart. Assumes TICK_DIV >= 2.
module wdt_tick_gen #(
    parameter int TICK_DIV = 60_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick
);
    localparam int PW = $clog2(TICK_DIV);
    localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

    logic [PW-1:0] phase;

    // Tick is issued on the last phase value of each period.
    assign tick = run && !restart && (phase == LAST);

    // Phase counter, cleared on reset, stop or restart.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || restart) begin
            phase <= '0;
        end else if (phase == LAST) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end
endmodule

// File: rtl/wdt_down_counter.sv
// Watchdog down-counter. Loads the start value on a reload and on an
// expiry, and steps down on each tick. An expiry is a tick seen with the
// count at zero. Assumes load_val is never below the legal minimum.
module wdt_down_counter #(
    parameter int CNT_W = 10,
    parameter logic [CNT_W-1:0] START_RST = 10'd30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    // Expiry is the tick that finds the count already at zero.
    assign expire = tick && (count == '0);

    // Count register: reload wins, then expiry reload, then decrement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= START_RST;
        end else if (load || expire) begin
            count <= load_val;
        end else if (tick) begin
            count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/wdt_stage_ctrl.sv
// Two-stage escalation. The first expiry sets the first flag. An expiry
// while that flag is set sets the second and boot flags and issues a
// one-cycle reset request unless no_reboot masks it. Set wins over a
// same-cycle write-1-to-clear.
module wdt_stage_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic no_reboot,
    input  logic clr_first,
    input  logic clr_second,
    input  logic clr_boot,
    output logic first_flag,
    output logic second_flag,
    output logic boot_flag,
    output logic reset_req
);
    logic escalate;

    // Second-stage event: expiry with the first stage still pending.
    assign escalate = expire && first_flag;

    // Status flags with set-over-clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_flag  <= 1'b0;
            second_flag <= 1'b0;
            boot_flag   <= 1'b0;
        end else begin
            first_flag  <= expire   || (first_flag  && !clr_first);
            second_flag <= escalate || (second_flag && !clr_second);
            boot_flag   <= escalate || (boot_flag   && !clr_boot);
        end
    end

    // Registered reset request pulse, gated by the no-reboot control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reset_req <= 1'b0;
        end else begin
            reset_req <= escalate && !no_reboot;
        end
    end
endmodule

// File: rtl/wdt_reg_file.sv
// Register decode and storage: start value, control image and the read
// mux. Illegal start values (below the minimum) are dropped. Status bits
// come in from the stage controller and leave as write-1-to-clear strobes.
module wdt_reg_file
    import wdt_pkg::*;
#(
    parameter int CNT_W = 10,
    parameter logic [CNT_W-1:0] START_RST = 10'd30
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic [WDT_ADDR_W-1:0] bus_addr,
    input  logic [WDT_DATA_W-1:0] bus_wdata,
    output logic [WDT_DATA_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0]      count,
    input  logic                  first_flag,
    input  logic                  second_flag,
    input  logic                  boot_flag,
    output logic [CNT_W-1:0]      start_val,
    output logic                  halt,
    output logic                  no_reboot,
    output logic                  reload_wr,
    output logic                  clr_first,
    output logic                  clr_second,
    output logic                  clr_boot
);
    localparam logic [CNT_W-1:0] MIN_START = CNT_W'(WDT_MIN_START);

    wdt_sel_e sel;
    logic [WDT_DATA_W-1:0] ctrl_q;
    logic [WDT_DATA_W-1:0] stat1_img;
    logic [WDT_DATA_W-1:0] stat2_img;

    // Address decode into a register select.
    always_comb begin
        unique case (bus_addr)
            OFS_RELOAD: sel = SEL_RELOAD;
            OFS_STAT1:  sel = SEL_STAT1;
            OFS_STAT2:  sel = SEL_STAT2;
            OFS_CTRL:   sel = SEL_CTRL;
            OFS_START:  sel = SEL_START;
            default:    sel = SEL_NONE;
        endcase
    end

    // Write strobes toward the counter and the stage controller.
    assign reload_wr  = bus_wr && (sel == SEL_RELOAD);
    assign clr_first  = bus_wr && (sel == SEL_STAT1) && bus_wdata[BIT_FIRST];
    assign clr_second = bus_wr && (sel == SEL_STAT2) && bus_wdata[BIT_SECOND];
    assign clr_boot   = bus_wr && (sel == SEL_STAT2) && bus_wdata[BIT_BOOT];

    // Start value register; writes below the minimum are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_val <= START_RST;
        end else if (bus_wr && (sel == SEL_START) &&
                     (bus_wdata[CNT_W-1:0] >= MIN_START)) begin
            start_val <= bus_wdata[CNT_W-1:0];
        end
    end

    // Control image, read back exactly as written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST;
        end else if (bus_wr && (sel == SEL_CTRL)) begin
            ctrl_q <= bus_wdata;
        end
    end

    assign halt      = ctrl_q[BIT_HALT];
    assign no_reboot = ctrl_q[BIT_NOREBOOT];

    // Status images placing each flag at its software-visible position.
    always_comb begin
        stat1_img = '0;
        stat1_img[BIT_FIRST] = first_flag;
        stat2_img = '0;
        stat2_img[BIT_SECOND] = second_flag;
        stat2_img[BIT_BOOT]   = boot_flag;
    end

    // Read mux.
    always_comb begin
        unique case (sel)
            SEL_RELOAD: bus_rdata = WDT_DATA_W'(count);
            SEL_STAT1:  bus_rdata = stat1_img;
            SEL_STAT2:  bus_rdata = stat2_img;
            SEL_CTRL:   bus_rdata = ctrl_q;
            SEL_START:  bus_rdata = WDT_DATA_W'(start_val);
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/wdt_twostage.sv
// Two-stage watchdog top. Connects the prescaler, the down-counter, the
// escalation logic and the register file. Assumes CNT_W <= 16 and
// START_RST >= 4.
module wdt_twostage
    import wdt_pkg::*;
#(
    parameter int TICK_DIV = 60_000_000,
    parameter int CNT_W = 10,
    parameter logic [CNT_W-1:0] START_RST = 10'd30
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic [WDT_ADDR_W-1:0] bus_addr,
    input  logic [WDT_DATA_W-1:0] bus_wdata,
    output logic [WDT_DATA_W-1:0] bus_rdata,
    output logic                  reset_req
);
    logic             tick;
    logic             expire;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] start_val;
    logic             halt;
    logic             no_reboot;
    logic             reload_wr;
    logic             clr_first;
    logic             clr_second;
    logic             clr_boot;
    logic             first_flag;
    logic             second_flag;
    logic             boot_flag;

    wdt_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (!halt),
        .restart (reload_wr),
        .tick    (tick)
    );

    wdt_down_counter #(.CNT_W(CNT_W), .START_RST(START_RST)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load     (reload_wr),
        .load_val (start_val),
        .count    (count),
        .expire   (expire)
    );

    wdt_stage_ctrl u_stage (
        .clk         (clk),
        .rst_n       (rst_n),
        .expire      (expire),
        .no_reboot   (no_reboot),
        .clr_first   (clr_first),
        .clr_second  (clr_second),
        .clr_boot    (clr_boot),
        .first_flag  (first_flag),
        .second_flag (second_flag),
        .boot_flag   (boot_flag),
        .reset_req   (reset_req)
    );

    wdt_reg_file #(.CNT_W(CNT_W), .START_RST(START_RST)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .count       (count),
        .first_flag  (first_flag),
        .second_flag (second_flag),
        .boot_flag   (boot_flag),
        .start_val   (start_val),
        .halt        (halt),
        .no_reboot   (no_reboot),
        .reload_wr   (reload_wr),
        .clr_first   (clr_first),
        .clr_second  (clr_second),
        .clr_boot    (clr_boot)
    );
endmodule

// File: rtl/wdt_twostage_checker.sv
// Property checker for the two-stage watchdog, bound to the top module.
// It observes the reset pulse, the flags, the control bits and the count.
module wdt_twostage_checker
    import wdt_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reset_req,
    input logic             halt,
    input logic             no_reboot,
    input logic             reload_wr,
    input logic             first_flag,
    input logic             second_flag,
    input logic             boot_flag,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] start_val
);
    AST_START_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        start_val >= CNT_W'(WDT_MIN_START)); // R3

    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !reload_wr) |=> $stable(count)); // R6

    AST_FIRST_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> first_flag); // R7

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> !reset_req); // R8

    AST_PULSE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> (second_flag && boot_flag)); // R8

    AST_PULSE_NEEDS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> $past(first_flag)); // R9

    AST_NOREBOOT_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> !$past(no_reboot)); // R10
endmodule

bind wdt_twostage wdt_twostage_checker #(.CNT_W(CNT_W)) u_wdt_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reset_req   (reset_req),
    .halt        (halt),
    .no_reboot   (no_reboot),
    .reload_wr   (reload_wr),
    .first_flag  (first_flag),
    .second_flag (second_flag),
    .boot_flag   (boot_flag),
    .count       (count),
    .start_val   (start_val)
);

// File: tb/test_wdt_twostage.sv
module test_wdt_twostage;
    localparam int DIV = 4;
    localparam int NRST = 4;
    localparam logic [4:0] A_RLD = 5'h00, A_S1 = 5'h04, A_S2 = 5'h06,
                           A_CTL = 5'h08, A_INI = 5'h12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        reset_req;

    wdt_twostage #(.TICK_DIV(DIV), .CNT_W(10), .START_RST(10'(NRST))) i_wdt_twostage (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .reset_req (reset_req)
    );

    always #2 clk = ~clk;

    typedef struct {
        logic [15:0] exp;
        string       tag;
    } item_t;

    item_t sbq[$];
    logic  rd_flag = 1'b0;
    int    cyc = 0;
    int    base = 0;
    int    checks = 0;
    int    fails = 0;
    int    pulses = 0;
    int    pulse_m = -1;
    bit    done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compares each read against the queued expectation, counts pulses.
    always @(negedge clk) begin
        if (rd_flag) begin
            item_t it;
            it = sbq.pop_front();
            checks++;
            if (bus_rdata !== it.exp) begin
                fails++;
                $display("FAIL %s actual=%h expected=%h", it.tag, bus_rdata, it.exp);
            end
        end
        if (rst_n && reset_req) begin
            pulses++;
            pulse_m = cyc - base;
        end
    end

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic reload();
        wr(A_RLD, 16'h5A5A);
        base = cyc;
    endtask

    task automatic rd(input logic [4:0] a, input logic [15:0] e, input string tag);
        item_t it;
        it.exp = e; it.tag = tag;
        sbq.push_back(it);
        bus_addr = a; rd_flag = 1'b1;
        @(posedge clk); #1;
        rd_flag = 1'b0;
    endtask

    task automatic idle_to(input int t);
        while (cyc - base < t) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int e);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, e);
        end
    endtask

    function automatic logic [15:0] ecnt(input int n, input int mm);
        return 16'(n - ((mm % (DIV * (n + 1))) / DIV));
    endfunction

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state
        rd(A_RLD, 16'(NRST), "R1 count");
        rd(A_INI, 16'(NRST), "R1 start");
        rd(A_CTL, 16'h0800, "R1 ctrl");
        rd(A_S1, 16'h0000, "R1 stat1");
        rd(A_S2, 16'h0000, "R1 stat2");
        chk(pulses == 0, "R1 pulses", pulses, 0);
        // R2: field write, upper bits read zero
        wr(A_INI, 16'hFC06);
        rd(A_INI, 16'h0006, "R2 start");
        // R3: values 0..3 ignored, 4 accepted
        wr(A_INI, 16'h0002);
        rd(A_INI, 16'h0006, "R3 write 2");
        wr(A_INI, 16'h0003);
        rd(A_INI, 16'h0006, "R3 write 3");
        wr(A_INI, 16'h0400);
        rd(A_INI, 16'h0006, "R3 write 0");
        wr(A_INI, 16'h0004);
        rd(A_INI, 16'h0004, "R3 write 4");
        wr(A_INI, 16'h0006);
        // R6: halted counter holds after reload
        reload();
        idle_to(40);
        rd(A_RLD, 16'h0006, "R6 halted");
        // R4 / R5: run, count per tick
        wr(A_CTL, 16'h0000);
        rd(A_CTL, 16'h0000, "R10 ctrl readback");
        reload();
        rd(A_RLD, ecnt(6, 0), "R4 reload");
        idle_to(7);
        rd(A_RLD, ecnt(6, 7), "R5 m7");
        idle_to(11);
        rd(A_RLD, ecnt(6, 11), "R5 m11");
        idle_to(27);
        rd(A_RLD, 16'h0000, "R5 zero");
        // R7: first expiry at 28
        rd(A_S1, 16'h0008, "R7 first flag");
        rd(A_RLD, 16'h0006, "R7 reloaded");
        rd(A_S2, 16'h0000, "R7 stat2");
        chk(pulses == 0, "R7 no pulse", pulses, 0);
        // R8: second expiry at 56
        idle_to(55);
        rd(A_S2, 16'h0000, "R8 before");
        rd(A_S2, 16'h0006, "R8 flags");
        rd(A_S1, 16'h0008, "R8 stat1");
        wr(A_CTL, 16'h0800);
        idle_to(100);
        chk(pulses == 1, "R8 pulse count", pulses, 1);
        chk(pulse_m == 56, "R8 pulse cycle", pulse_m, 56);
        // R11: write-1-to-clear
        wr(A_S2, 16'h0000);
        rd(A_S2, 16'h0006, "R11 zero write");
        wr(A_S2, 16'h0002);
        rd(A_S2, 16'h0004, "R11 clear second");
        wr(A_S1, 16'h0000);
        rd(A_S1, 16'h0008, "R11 stat1 zero write");
        wr(A_S1, 16'h0008);
        rd(A_S1, 16'h0000, "R11 clear first");
        wr(A_S2, 16'h0004);
        rd(A_S2, 16'h0000, "R11 clear boot");
        // R9: clearing first flag restarts the sequence
        wr(A_CTL, 16'h0000);
        reload();
        idle_to(30);
        rd(A_S1, 16'h0008, "R9 first set");
        wr(A_S1, 16'h0008);
        rd(A_S1, 16'h0000, "R9 cleared");
        idle_to(57);
        rd(A_S1, 16'h0008, "R9 set again");
        rd(A_S2, 16'h0000, "R9 no second");
        wr(A_CTL, 16'h0800);
        chk(pulses == 1, "R9 no pulse", pulses, 1);
        wr(A_S1, 16'h0008);
        // R10: no-reboot masks the pulse, flags still set
        wr(A_CTL, 16'h0001);
        rd(A_CTL, 16'h0001, "R10 readback");
        reload();
        idle_to(60);
        rd(A_S2, 16'h0006, "R10 flags");
        rd(A_S1, 16'h0008, "R10 first");
        wr(A_CTL, 16'h0801);
        rd(A_CTL, 16'h0801, "R10 readback halt");
        chk(pulses == 1, "R10 masked", pulses, 1);
        repeat (4) @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog all-requirements actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule